// File: doc/BRIEF.md
# Two-Way Cache Hit-Invalidate Sequencer

This block carries out one maintenance operation on the tag array of a two-way set-associative secondary cache. The operation removes a single block, named by its physical block address, from the whole cache hierarchy. A start command selects a set from the address and reads the tag entries of both ways. It then decides whether either way holds the block. On a hit, three things follow in order. First, the primary caches are told which line to drop. Second, the hit entry is rewritten as invalid, with a freshly computed check code. Third, the per-set most-recently-used bit is turned to the other way. An external agent can optionally receive a notice that the block was removed.

The block keeps a sticky cache-hit status bit that software can clear. It flags two faults. One is a check-code mismatch on a tag that was read; this aborts the operation with nothing written. The other is a corrupt set in which both ways claim the block. The tag array sits inside the block. A fill port and a look-up port load entries and inspect them outside an operation.

Top module: `hit_inval_seq`

## Requirements
- R1: After reset, `busy`, `done`, `pinv_req`, `elim_req`, `ch_bit`, `cache_err` and `multi_hit_err` are 0. Every tag entry reads back as all zeros, with a check code of 0, and every MRU bit reads back as 0.
- R2: A way hits only when its stored tag equals `op_pa[39:13]` and its 2-bit state is not 00. The set is `op_pa[12:7]`. An entry in state 00 with a matching tag counts as a miss.
- R3: On a miss, `done` is high for the cycle after the second rising edge that follows the edge accepting `start`. No primary invalidate and no eliminate notice are issued, no tag entry or MRU bit changes, and `ch_bit` becomes 0.
- R4: On a hit, `pinv_req` pulses for exactly one cycle. `pinv_pa` carries the operation's block address, and `pinv_pidx` carries the primary-index field of the hit entry as it was read.
- R5: On a hit, the hit entry is rewritten. Its state becomes 00, its tag becomes the operation's tag, and its primary index becomes `op_va_idx` (virtual address bits 13:12).
- R6: The stored 6-bit check code covers a 31-bit payload laid out as {pidx[1:0], state[1:0], tag[26:0]}, with the tag in the low bits. Check bit k is the XOR of all payload bits whose position modulo 6 equals k. The fill port stores this code, with bit 0 inverted when `fill_corrupt` is 1.
- R7: After a hit on way w, the set's MRU bit reads back as the inverse of w.
- R8: When `elim_mode` was 1 at the start, `elim_req` pulses for one cycle, carrying the block address. This happens in the cycle after the tag rewrite. When `elim_mode` was 0, no pulse occurs.
- R9: `ch_bit` is set by a hit and cleared by a miss. A one-cycle `ch_clear` clears it while the block is idle. An operation aborted by a check-code error leaves it unchanged.
- R10: If both ways hit, only way 0 is rewritten and way 1 is left untouched. `multi_hit_err` reads 1 when `done` is high.
- R11: If either way read back holds a code that differs from R6, `cache_err` reads 1 when `done` is high, with miss latency. Nothing is invalidated, written or announced.
- R12: `busy` is high from the cycle after `start` is accepted through the `done` cycle. `done` lasts one cycle. A hit finishes after the fifth rising edge that follows acceptance. A `start` raised while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op_pa | input | 33 | Physical block address, bits 39:7 |
| op_va_idx | input | 2 | Virtual address bits 13:12 |
| elim_mode | input | 1 | Send an eliminate notice after a hit |
| ch_clear | input | 1 | Software clear of the cache-hit bit |
| fill_en | input | 1 | Write one tag entry when idle |
| fill_way | input | 1 | Way to fill |
| fill_set | input | 6 | Set to fill |
| fill_tag | input | 27 | Tag to fill |
| fill_state | input | 2 | State to fill |
| fill_pidx | input | 2 | Primary index to fill |
| fill_corrupt | input | 1 | Store a deliberately wrong check code |
| peek_set | input | 6 | Set to inspect |
| peek_way | input | 1 | Way to inspect |
| peek_tag | output | 27 | Inspected tag |
| peek_state | output | 2 | Inspected state |
| peek_pidx | output | 2 | Inspected primary index |
| peek_ecc | output | 6 | Inspected check code |
| peek_mru | output | 1 | MRU bit of the inspected set |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pinv_req | output | 1 | Primary-cache invalidate request |
| pinv_pa | output | 33 | Block address to invalidate |
| pinv_pidx | output | 2 | Primary index from the hit tag |
| elim_req | output | 1 | Eliminate notice pulse |
| elim_pa | output | 33 | Block address of the eliminated block |
| ch_bit | output | 1 | Sticky cache-hit status |
| cache_err | output | 1 | Check-code error on the last operation |
| multi_hit_err | output | 1 | Both ways hit on the last operation |

## Verification
A wrong hit decision shows up in the `done` latency of the same operation, three cycles short or long. It also appears as a missing or spurious `pinv_req` pulse. A wrong way choice or a wrong set index leaves a stale valid entry, or destroys a neighbour. The look-up port exposes this immediately after `done`, and a second operation on the same address shows it again. A wrong check-code computation has two effects. It changes `peek_ecc` after a rewrite. It also makes a later operation on that set abort with `cache_err`. A wrong sequencing of the FSM shifts `elim_req` relative to the tag write, and that is visible within one cycle.

// File: rtl/sinv_pkg.sv
`timescale 1ns/1ps
package sinv_pkg;
  localparam int ECC_W   = 6;
  localparam int PAY_MAX = 64;
  localparam logic [1:0] ST_INVALID = 2'b00;

  typedef enum logic [2:0] {
    S_IDLE, S_READ, S_CMP, S_PINV, S_WRTAG, S_NOTE, S_DONE
  } sinv_st_e;

  // interleaved parity: bit k folds every payload bit at a position = k mod ECC_W
  function automatic logic [ECC_W-1:0] ecc_of(input logic [PAY_MAX-1:0] p);
    logic [ECC_W-1:0] e;
    e = '0;
    for (int i = 0; i < PAY_MAX; i++) e[i % ECC_W] = e[i % ECC_W] ^ p[i];
    return e;
  endfunction
endpackage

// File: rtl/sinv_tag_store.sv
`timescale 1ns/1ps
module sinv_tag_store #(
  parameter int SET_W = 6,
  parameter int ENT_W = 37
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd_en,
  input  logic [SET_W-1:0]      rd_set,
  output logic [1:0][ENT_W-1:0] rd_ent,
  input  logic                  wr_en,
  input  logic                  wr_way,
  input  logic [SET_W-1:0]      wr_set,
  input  logic [ENT_W-1:0]      wr_ent,
  input  logic                  mru_we,
  input  logic [SET_W-1:0]      mru_set,
  input  logic                  mru_val,
  input  logic [SET_W-1:0]      pk_set,
  input  logic                  pk_way,
  output logic [ENT_W-1:0]      pk_ent,
  output logic                  pk_mru
);
  localparam int SETS = 1 << SET_W;

  logic [1:0][ENT_W-1:0] pk_all;
  logic [SETS-1:0]       mru_q;

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [ENT_W-1:0] mem [SETS];
    logic [ENT_W-1:0] rd_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int s = 0; s < SETS; s++) mem[s] <= '0;
        rd_q <= '0;
      end else begin
        if (wr_en && (wr_way == 1'(w))) mem[wr_set] <= wr_ent;
        if (rd_en) rd_q <= mem[rd_set];
      end
    end
    assign rd_ent[w] = rd_q;
    assign pk_all[w] = mem[pk_set];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mru_q <= '0;
    else if (mru_we) mru_q[mru_set] <= mru_val;
  end

  assign pk_ent = pk_all[pk_way];
  assign pk_mru = mru_q[pk_set];
endmodule

// File: rtl/sinv_hit_detect.sv
`timescale 1ns/1ps
module sinv_hit_detect
  import sinv_pkg::*;
#(
  parameter int TAG_W = 27,
  parameter int PAY_W = TAG_W + 4,
  parameter int ENT_W = PAY_W + ECC_W
) (
  input  logic [1:0][ENT_W-1:0] ents,
  input  logic [TAG_W-1:0]      addr_tag,
  output logic [1:0]            hit,
  output logic                  ecc_bad
);
  logic [1:0] bad;

  for (genvar w = 0; w < 2; w++) begin : g_cmp
    logic [TAG_W-1:0] tg;
    logic [1:0]       stt;
    logic [PAY_W-1:0] pay;
    logic [ECC_W-1:0] code;
    assign tg     = ents[w][TAG_W-1:0];
    assign stt    = ents[w][TAG_W+1:TAG_W];
    assign pay    = ents[w][PAY_W-1:0];
    assign code   = ents[w][ENT_W-1:PAY_W];
    assign hit[w] = (tg == addr_tag) && (stt != ST_INVALID);
    assign bad[w] = (ecc_of(PAY_MAX'(pay)) != code);
  end

  assign ecc_bad = |bad;
endmodule

// File: rtl/sinv_ctrl.sv
`timescale 1ns/1ps
module sinv_ctrl
  import sinv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] hit,
  input  logic       ecc_bad,
  input  logic       ch_clear,
  output logic       accept,
  output logic       rd_en,
  output logic       hit_ev,
  output logic       miss_ev,
  output logic       abort_ev,
  output logic       pinv_ev,
  output logic       wr_ev,
  output logic       note_ev,
  output logic       done,
  output logic       busy,
  output logic       hit_way_q,
  output logic       cache_err,
  output logic       multi_err,
  output logic       ch_bit
);
  sinv_st_e st, st_nx;
  logic     cmp_ev;

  always_comb begin
    st_nx = st;
    unique case (st)
      S_IDLE:  if (start) st_nx = S_READ;
      S_READ:  st_nx = S_CMP;
      S_CMP:   st_nx = (!ecc_bad && (hit != 2'b00)) ? S_PINV : S_DONE;
      S_PINV:  st_nx = S_WRTAG;
      S_WRTAG: st_nx = S_NOTE;
      S_NOTE:  st_nx = S_DONE;
      S_DONE:  st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  assign accept   = (st == S_IDLE) && start;
  assign rd_en    = (st == S_READ);
  assign cmp_ev   = (st == S_CMP);
  assign abort_ev = cmp_ev && ecc_bad;
  assign hit_ev   = cmp_ev && !ecc_bad && (hit != 2'b00);
  assign miss_ev  = cmp_ev && !ecc_bad && (hit == 2'b00);
  assign pinv_ev  = (st == S_PINV);
  assign wr_ev    = (st == S_WRTAG);
  assign note_ev  = (st == S_NOTE);
  assign done     = (st == S_DONE);
  assign busy     = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      hit_way_q <= 1'b0;
      cache_err <= 1'b0;
      multi_err <= 1'b0;
      ch_bit    <= 1'b0;
    end else begin
      st <= st_nx;
      if (accept) begin
        cache_err <= 1'b0;
        multi_err <= 1'b0;
      end
      if (abort_ev) cache_err <= 1'b1;
      if (hit_ev) begin
        hit_way_q <= ~hit[0];          // way 0 wins when both claim the block
        multi_err <= &hit;
      end
      if (hit_ev)        ch_bit <= 1'b1;
      else if (miss_ev)  ch_bit <= 1'b0;
      else if (ch_clear) ch_bit <= 1'b0;
    end
  end
endmodule

// File: rtl/hit_inval_seq.sv
`timescale 1ns/1ps
module hit_inval_seq
  import sinv_pkg::*;
#(
  parameter int PA_W  = 40,
  parameter int OFF_W = 7,
  parameter int SET_W = 6,
  localparam int BA_W  = PA_W - OFF_W,
  localparam int TAG_W = PA_W - OFF_W - SET_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [BA_W-1:0]  op_pa,
  input  logic [1:0]       op_va_idx,
  input  logic             elim_mode,
  input  logic             ch_clear,
  input  logic             fill_en,
  input  logic             fill_way,
  input  logic [SET_W-1:0] fill_set,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [1:0]       fill_state,
  input  logic [1:0]       fill_pidx,
  input  logic             fill_corrupt,
  input  logic [SET_W-1:0] peek_set,
  input  logic             peek_way,
  output logic [TAG_W-1:0] peek_tag,
  output logic [1:0]       peek_state,
  output logic [1:0]       peek_pidx,
  output logic [ECC_W-1:0] peek_ecc,
  output logic             peek_mru,
  output logic             busy,
  output logic             done,
  output logic             pinv_req,
  output logic [BA_W-1:0]  pinv_pa,
  output logic [1:0]       pinv_pidx,
  output logic             elim_req,
  output logic [BA_W-1:0]  elim_pa,
  output logic             ch_bit,
  output logic             cache_err,
  output logic             multi_hit_err
);
  localparam int PAY_W = TAG_W + 4;
  localparam int ENT_W = PAY_W + ECC_W;

  logic [BA_W-1:0]       pa_q;
  logic [1:0]            vidx_q;
  logic                  elim_q;
  logic [SET_W-1:0]      set_q;
  logic [TAG_W-1:0]      tag_q;
  logic [1:0][ENT_W-1:0] rd_ent;
  logic [1:0]            hit;
  logic                  ecc_bad;
  logic                  accept, rd_en, hit_ev, miss_ev, abort_ev;
  logic                  pinv_ev, wr_ev, note_ev, hit_way_q;
  logic [PAY_W-1:0]      new_pay, fill_pay;
  logic [ENT_W-1:0]      new_ent, fill_ent, wr_ent, pk_ent;
  logic                  fill_ok, wr_en, wr_way;
  logic [SET_W-1:0]      wr_set;

  assign set_q = pa_q[SET_W-1:0];
  assign tag_q = pa_q[BA_W-1:SET_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q   <= '0;
      vidx_q <= '0;
      elim_q <= 1'b0;
    end else if (accept) begin
      pa_q   <= op_pa;
      vidx_q <= op_va_idx;
      elim_q <= elim_mode;
    end
  end

  sinv_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .hit(hit), .ecc_bad(ecc_bad),
    .ch_clear(ch_clear), .accept(accept), .rd_en(rd_en), .hit_ev(hit_ev),
    .miss_ev(miss_ev), .abort_ev(abort_ev), .pinv_ev(pinv_ev), .wr_ev(wr_ev),
    .note_ev(note_ev), .done(done), .busy(busy), .hit_way_q(hit_way_q),
    .cache_err(cache_err), .multi_err(multi_hit_err), .ch_bit(ch_bit)
  );

  sinv_hit_detect #(.TAG_W(TAG_W)) u_hit (
    .ents(rd_ent), .addr_tag(tag_q), .hit(hit), .ecc_bad(ecc_bad)
  );

  // rewritten entry: invalid state, same tag, virtual index bits
  assign new_pay  = {vidx_q, ST_INVALID, tag_q};
  assign new_ent  = {ecc_of(PAY_MAX'(new_pay)), new_pay};
  assign fill_pay = {fill_pidx, fill_state, fill_tag};
  assign fill_ent = {ecc_of(PAY_MAX'(fill_pay)) ^ {{(ECC_W-1){1'b0}}, fill_corrupt}, fill_pay};

  assign fill_ok = fill_en && !busy;
  assign wr_en   = wr_ev || fill_ok;
  assign wr_way  = wr_ev ? hit_way_q : fill_way;
  assign wr_set  = wr_ev ? set_q : fill_set;
  assign wr_ent  = wr_ev ? new_ent : fill_ent;

  sinv_tag_store #(.SET_W(SET_W), .ENT_W(ENT_W)) u_store (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_set(set_q), .rd_ent(rd_ent),
    .wr_en(wr_en), .wr_way(wr_way), .wr_set(wr_set), .wr_ent(wr_ent),
    .mru_we(wr_ev), .mru_set(set_q), .mru_val(~hit_way_q),
    .pk_set(peek_set), .pk_way(peek_way), .pk_ent(pk_ent), .pk_mru(peek_mru)
  );

  assign peek_tag   = pk_ent[TAG_W-1:0];
  assign peek_state = pk_ent[TAG_W+1:TAG_W];
  assign peek_pidx  = pk_ent[TAG_W+3:TAG_W+2];
  assign peek_ecc   = pk_ent[ENT_W-1:PAY_W];

  assign pinv_req  = pinv_ev;
  assign pinv_pa   = pa_q;
  assign pinv_pidx = rd_ent[hit_way_q][TAG_W+3:TAG_W+2];
  assign elim_req  = note_ev && elim_q;
  assign elim_pa   = pa_q;
endmodule

// File: rtl/sinv_chk.sv
`timescale 1ns/1ps
module sinv_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic pinv_req,
  input logic elim_req,
  input logic ch_bit,
  input logic hit_ev,
  input logic miss_ev,
  input logic abort_ev,
  input logic wr_ev,
  input logic wr_way,
  input logic multi_hit_err
);
  // R4
  pinv_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pinv_req |=> !pinv_req);
  // R12
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R12
  busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  // R8
  elim_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    elim_req |-> $past(wr_ev));
  // R3
  miss_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_ev |=> (done && !pinv_req));
  // R11
  abort_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ev |=> (done && !pinv_req && !wr_ev));
  // R9
  ch_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ch_bit) |-> $past(hit_ev));
  // R10
  multi_way0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ev && multi_hit_err) |-> (wr_way == 1'b0));
endmodule

bind hit_inval_seq sinv_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .pinv_req(pinv_req), .elim_req(elim_req), .ch_bit(ch_bit),
  .hit_ev(hit_ev), .miss_ev(miss_ev), .abort_ev(abort_ev), .wr_ev(wr_ev),
  .wr_way(wr_way), .multi_hit_err(multi_hit_err)
);

// File: tb/hit_inval_seq_tb.sv
`timescale 1ns/1ps
module hit_inval_seq_tb;
  localparam int SET_W = 6;
  localparam int TAG_W = 27;
  localparam int BA_W  = TAG_W + SET_W;
  localparam int SETS  = 1 << SET_W;

  logic clk = 0, rst_n = 0;
  logic start = 0, elim_mode = 0, ch_clear = 0;
  logic [BA_W-1:0] op_pa = '0;
  logic [1:0] op_va_idx = '0;
  logic fill_en = 0, fill_way = 0, fill_corrupt = 0;
  logic [SET_W-1:0] fill_set = '0, peek_set = '0;
  logic [TAG_W-1:0] fill_tag = '0;
  logic [1:0] fill_state = '0, fill_pidx = '0;
  logic peek_way = 0;
  logic [TAG_W-1:0] peek_tag;
  logic [1:0] peek_state, peek_pidx, pinv_pidx;
  logic [5:0] peek_ecc;
  logic peek_mru, busy, done, pinv_req, elim_req, ch_bit, cache_err, multi_hit_err;
  logic [BA_W-1:0] pinv_pa, elim_pa;

  always #2.5 clk = ~clk;

  hit_inval_seq u_dut (.*);

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // bench copy of the tag array
  logic [TAG_W-1:0] m_tag [2][SETS];
  logic [1:0] m_st [2][SETS];
  logic [1:0] m_px [2][SETS];
  bit m_bad [2][SETS];
  bit m_mru [SETS];
  bit m_ch = 0;

  function automatic logic [5:0] becc(input logic [1:0] px, input logic [1:0] s,
                                      input logic [TAG_W-1:0] t);
    logic [63:0] p;
    logic [5:0] e;
    p = 64'({px, s, t});
    e = '0;
    for (int k = 0; k < 6; k++)
      for (int i = k; i < 64; i += 6) e[k] ^= p[i];
    return e;
  endfunction

  typedef struct {
    int t0; int lat; bit pinv; logic [BA_W-1:0] ba; logic [1:0] px;
    bit elim; bit cerr; bit merr; bit ch; string req;
  } exp_t;
  exp_t q[$];
  exp_t e;
  int n_pinv = 0, n_elim = 0;
  logic [BA_W-1:0] s_pinv_pa, s_elim_pa;
  logic [1:0] s_px;

  // monitor: gather pulses, compare at done
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (pinv_req) begin n_pinv++; s_pinv_pa = pinv_pa; s_px = pinv_pidx; end
      if (elim_req) begin n_elim++; s_elim_pa = elim_pa; end
      if (done) begin
        if (q.size() == 0) chk(0, "R12", "done with no operation pending", 1, 0);
        else begin
          e = q.pop_front();
          chk(cyc - e.t0 == e.lat, e.req, "R12 latency", 64'(cyc - e.t0), 64'(e.lat));
          chk(n_pinv == (e.pinv ? 1 : 0), e.req, "R4 pinv count", 64'(n_pinv), 64'(e.pinv));
          if (e.pinv) begin
            chk(s_pinv_pa == e.ba, e.req, "R4 pinv_pa", 64'(s_pinv_pa), 64'(e.ba));
            chk(s_px == e.px, e.req, "R4 pinv_pidx", 64'(s_px), 64'(e.px));
          end
          chk(n_elim == (e.elim ? 1 : 0), e.req, "R8 elim count", 64'(n_elim), 64'(e.elim));
          if (e.elim) chk(s_elim_pa == e.ba, e.req, "R8 elim_pa", 64'(s_elim_pa), 64'(e.ba));
          chk(cache_err == e.cerr, e.req, "R11 cache_err", 64'(cache_err), 64'(e.cerr));
          chk(multi_hit_err == e.merr, e.req, "R10 multi_hit_err", 64'(multi_hit_err), 64'(e.merr));
          chk(ch_bit == e.ch, e.req, "R9 ch_bit", 64'(ch_bit), 64'(e.ch));
          n_pinv = 0; n_elim = 0;
        end
      end
    end
  end

  task automatic fill(input bit w, input int s, input logic [TAG_W-1:0] t,
                      input logic [1:0] st, input logic [1:0] px, input bit bad);
    @(negedge clk);
    fill_en = 1; fill_way = w; fill_set = SET_W'(s); fill_tag = t;
    fill_state = st; fill_pidx = px; fill_corrupt = bad;
    @(negedge clk);
    fill_en = 0; fill_corrupt = 0;
    m_tag[w][s] = t; m_st[w][s] = st; m_px[w][s] = px; m_bad[w][s] = bad;
  endtask

  task automatic peek(input bit w, input int s, input string req);
    logic [5:0] ex;
    @(negedge clk);
    peek_way = w; peek_set = SET_W'(s);
    #1;
    ex = becc(m_px[w][s], m_st[w][s], m_tag[w][s]) ^ {5'b0, m_bad[w][s]};
    chk(peek_tag == m_tag[w][s], req, "peek tag", 64'(peek_tag), 64'(m_tag[w][s]));
    chk(peek_state == m_st[w][s], req, "peek state", 64'(peek_state), 64'(m_st[w][s]));
    chk(peek_pidx == m_px[w][s], req, "peek pidx", 64'(peek_pidx), 64'(m_px[w][s]));
    chk(peek_ecc == ex, "R6", "peek ecc", 64'(peek_ecc), 64'(ex));
    chk(peek_mru == m_mru[s], "R7", "peek mru", 64'(peek_mru), 64'(m_mru[s]));
  endtask

  // driver: predict, push, issue, wait
  task automatic run_op(input logic [TAG_W-1:0] t, input int s, input logic [1:0] vi,
                        input bit mode, input string req, input bit poke,
                        input logic [BA_W-1:0] poke_pa);
    exp_t x;
    bit h0, h1, bad;
    h0 = (m_tag[0][s] == t) && (m_st[0][s] != 2'b00);
    h1 = (m_tag[1][s] == t) && (m_st[1][s] != 2'b00);
    bad = m_bad[0][s] || m_bad[1][s];
    x.ba = {t, SET_W'(s)}; x.req = req; x.px = '0;
    x.pinv = 0; x.elim = 0; x.cerr = 0; x.merr = 0; x.lat = 3;
    if (bad) begin
      x.cerr = 1;
    end else if (h0 || h1) begin
      int w;
      w = h0 ? 0 : 1;
      x.lat = 6; x.pinv = 1; x.px = m_px[w][s]; x.elim = mode; x.merr = h0 && h1;
      m_st[w][s] = 2'b00; m_px[w][s] = vi; m_bad[w][s] = 0; m_mru[s] = (w == 0);
      m_ch = 1;
    end else begin
      m_ch = 0;
    end
    x.ch = m_ch;
    @(negedge clk);
    x.t0 = cyc;
    q.push_back(x);
    start = 1; op_pa = x.ba; op_va_idx = vi; elim_mode = mode;
    @(negedge clk);
    start = 0;
    chk(busy == 1, "R12", "busy after start", 64'(busy), 1);
    if (poke) begin
      start = 1; op_pa = poke_pa;
      @(negedge clk);
      start = 0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(busy == 0 && !done, "R12", "idle after done", 64'({busy, done}), 0);
  endtask

  initial begin
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < SETS; s++) begin
        m_tag[w][s] = '0; m_st[w][s] = '0; m_px[w][s] = '0; m_bad[w][s] = 0; m_mru[s] = 0;
      end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({busy, done, pinv_req, elim_req, ch_bit, cache_err, multi_hit_err} == 0,
        "R1", "outputs in reset", 64'({busy, done, ch_bit, cache_err, multi_hit_err}), 0);
    rst_n = 1;
    peek(0, 0, "R1"); peek(1, 63, "R1");

    fill(0, 5, 27'h1234567, 2'b11, 2'd2, 0);
    fill(1, 5, 27'h0ABCDEF, 2'b01, 2'd1, 0);
    run_op(27'h7777777, 5, 2'd0, 1, "R3", 0, '0);          // miss
    peek(0, 5, "R3"); peek(1, 5, "R3");
    run_op(27'h0ABCDEF, 5, 2'd3, 1, "R5", 0, '0);          // hit way 1, notice on
    peek(1, 5, "R5"); peek(0, 5, "R5");
    run_op(27'h0ABCDEF, 5, 2'd0, 0, "R2", 0, '0);          // invalid now: miss, CH clears

    fill(1, 9, 27'h5A5A5A5, 2'b00, 2'd0, 0);                // matching tag, state 00
    run_op(27'h5A5A5A5, 9, 2'd1, 0, "R2", 0, '0);
    fill(0, 9, 27'h3C3C3C3, 2'b10, 2'd3, 0);
    run_op(27'h3C3C3C3, 9, 2'd2, 0, "R7", 0, '0);          // hit way 0, no notice
    peek(0, 9, "R7");

    @(negedge clk); ch_clear = 1; @(negedge clk); ch_clear = 0; m_ch = 0;
    chk(ch_bit == 0, "R9", "ch_clear", 64'(ch_bit), 0);

    fill(0, 20, 27'h00F00F0, 2'b01, 2'd1, 0);
    fill(1, 20, 27'h00F00F0, 2'b11, 2'd2, 0);
    run_op(27'h00F00F0, 20, 2'd3, 1, "R10", 0, '0);        // both ways claim it
    peek(0, 20, "R10"); peek(1, 20, "R10");

    fill(0, 30, 27'h1111111, 2'b01, 2'd0, 1);               // bad code on way 0
    fill(1, 30, 27'h2222222, 2'b01, 2'd1, 0);
    run_op(27'h2222222, 30, 2'd2, 1, "R11", 0, '0);        // abort, CH kept at 1
    peek(0, 30, "R11"); peek(1, 30, "R11");

    fill(0, 40, 27'h4444444, 2'b10, 2'd1, 0);
    fill(1, 41, 27'h6666666, 2'b01, 2'd2, 0);
    run_op(27'h4444444, 40, 2'd1, 0, "R12", 1, {27'h6666666, 6'd41});
    peek(1, 41, "R12"); peek(0, 40, "R12");

    chk(q.size() == 0, "R12", "pending operations", 64'(q.size()), 0);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL R12 watchdog actual=%0h expected=%0h", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule